// File: doc/BRIEF.md
# Flash Controller Interrupt Status and Mask Unit

This block gathers six event sources from a NAND flash controller: NAND ready, controller ready, decode failure, decode error, ECC ready and write-protect fault. Each one-cycle event pulse sets a sticky bit. The sticky bits are combined with a software mask to drive a single level interrupt line toward the processor. Software acknowledges every pending event with one read of the sticky register, which returns the bits and clears them.

A second, read-only view, the live status register, shows the current levels of the ready, ECC and error signals. It also packs the number of corrected symbol errors, stored as count minus one. The event and level generators sit outside this block. Access goes through a plain register port with a 2-bit select, a write strobe, a read strobe and combinational read data.

Top module: `nand_irq_unit`

## Requirements
- R1: Sticky and mask registers share one bit order: bit 5 NAND ready, bit 4 controller ready, bit 3 decode failure, bit 2 decode error, bit 1 ECC ready, bit 0 write-protect fault. An event pulse on evtIn bit n sets sticky bit n at the next clock edge.
- R2: A sticky bit, once set, stays set until the sticky register is read.
- R3: A read with select 1 returns the sticky bits on rdData[5:0] in the same cycle and clears all of them at the clock edge that ends the read.
- R4: An event that arrives in the same cycle as a sticky read is set again after the clear, so a following read returns it.
- R5: A write with select 0 loads wrData[5:0] into the mask, and a read with select 0 returns it. A mask bit of 1 enables its source.
- R6: irqOut is registered. It is high one cycle after any sticky bit whose mask bit is 1 is set, and it stays high while such a bit remains set. It goes low one cycle after no such bit remains.
- R7: The live status register (select 2) places levels as follows: bit 0 NAND ready, bit 1 controller ready, bit 2 ECC ready, bit 3 errors detected, bit 6 decoder failure. Bit 7 is 0.
- R8: Live status bits 5:4 hold corrCnt minus one when errors detected is 1 and decoder failure is 0. Otherwise they are 0.
- R9: After reset, mask, sticky bits and irqOut are all 0.
- R10: A read with select 3 returns 0. Sticky and mask bits 7:6 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 6 | Event pulses, in the sticky bit order |
| nandRdyLvl | input | 1 | Live NAND ready level |
| ctrlRdyLvl | input | 1 | Live controller ready level |
| eccRdyLvl | input | 1 | Live ECC ready level |
| errDetLvl | input | 1 | Live errors-detected level |
| decFailLvl | input | 1 | Live decoder failure level |
| corrCnt | input | 3 | Corrected symbol errors (1 to 4) |
| regSel | input | 2 | Register select: 0 mask, 1 sticky, 2 live, 3 none |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe (clears sticky when select is 1) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the current select |
| irqOut | output | 1 | Level interrupt |

## Verification
The embedded assertions check four behaviours on every cycle:
- sticky bits never drop without a read;
- a read leaves exactly the events of that cycle;
- the interrupt follows the masked sticky state one cycle later;
- the corrected-count field is zero whenever it is not meaningful.

Only the bench scenarios can show the other behaviours:
- the register map and bit orders as software sees them;
- the minus-one packing of the count;
- an event landing in the same cycle as a read being returned by the following read.

// File: rtl/nand_irq_pkg.sv
package nand_irq_pkg;
  localparam int SRC_N  = 6;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 2;

  localparam logic [SEL_W-1:0] SEL_MASK   = 2'd0;
  localparam logic [SEL_W-1:0] SEL_STICKY = 2'd1;
  localparam logic [SEL_W-1:0] SEL_LIVE   = 2'd2;

  // live status bit positions
  localparam int LV_NAND = 0;
  localparam int LV_CTRL = 1;
  localparam int LV_ECC  = 2;
  localparam int LV_ERR  = 3;
  localparam int LV_CNT  = 4;
  localparam int LV_FAIL = 6;

  typedef struct packed {
    logic maskWr;
    logic stickyClr;
  } isuStrobe_t;
endpackage

// File: rtl/nand_irq_ctrl.sv
module nand_irq_ctrl
  import nand_irq_pkg::*;
(
  input  logic [SEL_W-1:0] regSel,
  input  logic             regWr,
  input  logic             regRd,
  output isuStrobe_t       strb
);
  always_comb begin
    strb.maskWr    = regWr && (regSel == SEL_MASK);
    strb.stickyClr = regRd && (regSel == SEL_STICKY);
  end
endmodule

// File: rtl/nand_irq_datapath.sv
module nand_irq_datapath
  import nand_irq_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  isuStrobe_t        strb,
  input  logic [SRC_N-1:0]  evtIn,
  input  logic              nandRdyLvl,
  input  logic              ctrlRdyLvl,
  input  logic              eccRdyLvl,
  input  logic              errDetLvl,
  input  logic              decFailLvl,
  input  logic [CNT_W-1:0]  corrCnt,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  localparam int FLD_W = 2;
  localparam int PAD_W = DATA_W - SRC_N;

  logic [SRC_N-1:0]  maskReg;
  logic [SRC_N-1:0]  sticky;
  logic [SRC_N-1:0]  stickyNext;
  logic [DATA_W-1:0] liveStat;
  logic [FLD_W-1:0]  cntField;
  logic [CNT_W-1:0]  cntMinus;

  // mask register
  always_ff @(posedge clk) begin
    if (!rstN)            maskReg <= '0;
    else if (strb.maskWr) maskReg <= wrData[SRC_N-1:0];
  end

  // sticky bits: read clears, same-cycle events survive
  always_comb stickyNext = (strb.stickyClr ? '0 : sticky) | evtIn;

  always_ff @(posedge clk) begin
    if (!rstN) sticky <= '0;
    else       sticky <= stickyNext;
  end

  // registered interrupt level
  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(sticky & maskReg);
  end

  // live status packing
  always_comb begin
    cntMinus = corrCnt - CNT_W'(1);
    cntField = (errDetLvl && !decFailLvl) ? cntMinus[FLD_W-1:0] : '0;
    liveStat = '0;
    liveStat[LV_NAND] = nandRdyLvl;
    liveStat[LV_CTRL] = ctrlRdyLvl;
    liveStat[LV_ECC]  = eccRdyLvl;
    liveStat[LV_ERR]  = errDetLvl;
    liveStat[LV_CNT +: FLD_W] = cntField;
    liveStat[LV_FAIL] = decFailLvl;
  end

  always_comb begin
    unique case (regSel)
      SEL_MASK:   rdData = {{PAD_W{1'b0}}, maskReg};
      SEL_STICKY: rdData = {{PAD_W{1'b0}}, sticky};
      SEL_LIVE:   rdData = liveStat;
      default:    rdData = '0;
    endcase
  end

  // R2: without a clear no sticky bit drops
  assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.stickyClr |=> ((sticky & $past(sticky)) == $past(sticky)));

  // R3/R4: after a clear only that cycle's events remain
  assert_clear_keep_evt_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.stickyClr |=> (sticky == $past(evtIn)));

  // R6: interrupt follows masked sticky state one cycle later
  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|(sticky & maskReg)) |=> irqOut);
  assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(|(sticky & maskReg)) |=> !irqOut);

  // R8: count field zero when not meaningful
  always_comb begin
    if (rstN && (!errDetLvl || decFailLvl))
      assert_cnt_zero_R8: assert (liveStat[LV_CNT +: FLD_W] == '0);
  end
endmodule

// File: rtl/nand_irq_unit.sv
module nand_irq_unit
  import nand_irq_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SRC_N-1:0]  evtIn,
  input  logic              nandRdyLvl,
  input  logic              ctrlRdyLvl,
  input  logic              eccRdyLvl,
  input  logic              errDetLvl,
  input  logic              decFailLvl,
  input  logic [CNT_W-1:0]  corrCnt,
  input  logic [SEL_W-1:0]  regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  isuStrobe_t strb;

  nand_irq_ctrl u_ctrl (
    .regSel(regSel), .regWr(regWr), .regRd(regRd), .strb(strb)
  );

  nand_irq_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .evtIn(evtIn),
    .nandRdyLvl(nandRdyLvl), .ctrlRdyLvl(ctrlRdyLvl), .eccRdyLvl(eccRdyLvl),
    .errDetLvl(errDetLvl), .decFailLvl(decFailLvl), .corrCnt(corrCnt),
    .regSel(regSel), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );
endmodule

// File: tb/nand_irq_unit_tb.sv
`timescale 1ns/1ps
module nand_irq_unit_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [5:0] evtIn = '0;
  logic nandRdyLvl = 0, ctrlRdyLvl = 0, eccRdyLvl = 0, errDetLvl = 0, decFailLvl = 0;
  logic [2:0] corrCnt = 3'd1;
  logic [1:0] regSel = '0;
  logic regWr = 0, regRd = 0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic irqOut;
  int checks = 0;
  int failures = 0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  nand_irq_unit u_dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .nandRdyLvl(nandRdyLvl),
    .ctrlRdyLvl(ctrlRdyLvl), .eccRdyLvl(eccRdyLvl), .errDetLvl(errDetLvl),
    .decFailLvl(decFailLvl), .corrCnt(corrCnt), .regSel(regSel),
    .regWr(regWr), .regRd(regRd), .wrData(wrData), .rdData(rdData),
    .irqOut(irqOut)
  );

  // {mask, event, expected sticky, expected irq}
  localparam logic [18:0] VEC [6] = '{
    {6'h3F, 6'h20, 6'h20, 1'b1},
    {6'h00, 6'h3F, 6'h3F, 1'b0},
    {6'h01, 6'h02, 6'h02, 1'b0},
    {6'h12, 6'h10, 6'h10, 1'b1},
    {6'h2A, 6'h15, 6'h15, 1'b0},
    {6'h21, 6'h01, 6'h01, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [7:0] d);
    regSel = sel; wrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [7:0] d);
    regSel = sel; regRd = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 irq", {7'd0, irqOut}, 8'h00);
    regRead(2'd0, got); chk("R9 mask", got, 8'h00);
    regRead(2'd1, got); chk("R9 sticky", got, 8'h00);

    // table walk: R1 R5 R6 R3
    foreach (VEC[i]) begin
      regWrite(2'd0, {2'b11, VEC[i][18:13]});
      regRead(2'd0, got); chk("R5 mask readback", got, {2'b00, VEC[i][18:13]});
      evtIn = VEC[i][12:7];
      @(negedge clk);
      evtIn = '0;
      @(negedge clk);
      chk("R6 irq level", {7'd0, irqOut}, {7'd0, VEC[i][0]});
      regRead(2'd1, got); chk("R1 sticky bits", got, {2'b00, VEC[i][6:1]});
      @(negedge clk);
      chk("R3 cleared irq", {7'd0, irqOut}, 8'h00);
      regRead(2'd1, got); chk("R3 cleared sticky", got, 8'h00);
    end

    // R2 hold over many cycles
    regWrite(2'd0, 8'h08);
    evtIn = 6'h08; @(negedge clk); evtIn = '0;
    repeat (10) @(negedge clk);
    chk("R2 irq held", {7'd0, irqOut}, 8'h01);
    regRead(2'd1, got); chk("R2 sticky held", got, 8'h08);

    // R4 event during read
    evtIn = 6'h04; @(negedge clk); evtIn = '0;
    regSel = 2'd1; regRd = 1'b1; evtIn = 6'h02;
    #1 got = rdData;
    chk("R4 read value", got, 8'h04);
    @(negedge clk);
    regRd = 1'b0; evtIn = '0;
    regRead(2'd1, got); chk("R4 event kept", got, 8'h02);

    // R7 live bit order
    nandRdyLvl = 1; #1 regRead(2'd2, got); chk("R7 nand", got, 8'h01);
    nandRdyLvl = 0; ctrlRdyLvl = 1; #1 regRead(2'd2, got); chk("R7 ctrl", got, 8'h02);
    ctrlRdyLvl = 0; eccRdyLvl = 1; #1 regRead(2'd2, got); chk("R7 ecc", got, 8'h04);
    eccRdyLvl = 0; decFailLvl = 1; #1 regRead(2'd2, got); chk("R7 fail", got, 8'h40);

    // R8 count packing
    decFailLvl = 0; errDetLvl = 1; corrCnt = 3'd3;
    #1 regRead(2'd2, got); chk("R8 count 3", got, 8'h28);
    corrCnt = 3'd4; #1 regRead(2'd2, got); chk("R8 count 4", got, 8'h38);
    corrCnt = 3'd1; #1 regRead(2'd2, got); chk("R8 count 1", got, 8'h08);
    corrCnt = 3'd3; decFailLvl = 1; #1 regRead(2'd2, got); chk("R8 fail zero", got, 8'h48);
    errDetLvl = 0; decFailLvl = 0; #1 regRead(2'd2, got); chk("R8 noerr zero", got, 8'h00);

    // R10 unused select and pad bits
    evtIn = 6'h3F; @(negedge clk); evtIn = '0;
    regRead(2'd3, got); chk("R10 select 3", got, 8'h00);
    regRead(2'd1, got); chk("R10 sticky pad", got, 8'h3F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule